// File: doc/BRIEF.md
# Corrected-Bit Error Statistics Counter

This block sits behind a Reed-Solomon decoder and watches two symbol streams that arrive on the same beat. One is the corrected output symbol. The other is the error value the decoder applied to it, so the corrected symbol equals the received symbol XOR the error value. The block adds up, for each codeword, how many symbols were corrected and how many bits were corrected. A symbol counts as corrected when its error value is nonzero. Each 1 bit in an error value is one corrected bit.

A build-time mode picks how bits are counted. In full mode there is one total. In split mode there are two counts. The first counts bits whose corrected value is 0, meaning the bit was flipped from 1 to 0. The second counts bits whose corrected value is 1, meaning the bit was flipped from 0 to 1. The outputs of the mode that is not built are held at zero.

A codeword's statistics are published when the next codeword's start beat is accepted. They come with a one-cycle valid pulse and a decode-failure flag. When the decoder signalled failure for that codeword, every count is published as zero and the flag is set.

Top module: `rs_corr_stats`

## Requirements
- R1: While reset is asserted and after it is released, `stat_valid`, `stat_fail` and every count output are 0 until the first publication.
- R2: `stat_sym` equals the number of accepted beats of the codeword whose error value is nonzero.
- R3: With MODE = CNT_FULL, `stat_total` equals the number of 1 bits across all accepted error values of the codeword. `stat_fall` and `stat_rise` stay 0.
- R4: With MODE = CNT_SPLIT, the two split counts are defined as follows, and `stat_total` stays 0.
  - `stat_fall` counts bits where the error value bit is 1 and the corrected symbol bit is 0.
  - `stat_rise` counts bits where the error value bit is 1 and the corrected symbol bit is 1.
- R5: A closed codeword's results are published in the first clock cycle after the next accepted start beat (`in_valid` and `in_sop` both 1). In that cycle `stat_valid` is 1 for exactly that cycle. At all other times `stat_valid` is 0 and the count outputs hold their last published values.
- R6: A start beat with no previously closed codeword pending, such as the first start beat after reset, publishes nothing.
- R7: The following beats contribute nothing, whatever their data and flags:
  - beats with `in_valid` low;
  - valid beats that arrive after the closing beat and before the next start beat.
- R8: If `in_fail` is 1 on any accepted beat of a codeword, its publication carries `stat_fail` = 1 and all count outputs 0.
- R9: A beat with both `in_sop` and `in_eop` set forms a complete one-symbol codeword.
- R10: Counts do not wrap for a codeword of up to N_MAX symbols with every bit in error. The symbol count is $clog2(N_MAX+1) bits wide and each bit count is $clog2(N_MAX*SYM_W+1) bits wide.
- R11: A start beat that arrives while a codeword is still open (no closing beat yet) discards the partial codeword, publishes nothing, and starts a new accumulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat qualifier |
| in_sop | input | 1 | First beat of a codeword |
| in_eop | input | 1 | Last beat of a codeword |
| in_sym | input | SYM_W | Corrected output symbol |
| in_err | input | SYM_W | Error value applied to that symbol |
| in_fail | input | 1 | Decoder failure flag for the current codeword |
| stat_valid | output | 1 | One-cycle publication pulse |
| stat_fail | output | 1 | Published codeword failed to decode |
| stat_sym | output | $clog2(N_MAX+1) | Corrected symbol count |
| stat_total | output | $clog2(N_MAX*SYM_W+1) | Corrected bit total (full mode) |
| stat_fall | output | $clog2(N_MAX*SYM_W+1) | Bits corrected to 0 (split mode) |
| stat_rise | output | $clog2(N_MAX*SYM_W+1) | Bits corrected to 1 (split mode) |

## Verification
Inputs pass through two register stages before the outputs. Each beat is added into the accumulators at its clock edge. The accumulated values are copied to the outputs at the edge of the next start beat. As a result, a codeword's results are visible exactly one cycle after that start beat's edge. The bench drives beats on falling edges and records the outputs on the falling edge that follows the start beat. Each accepted start beat is checked against the expected values that the bench computed on its own from the previous codeword. Hold behaviour is checked on idle falling edges after a publication. Two instances, one per mode, receive identical stimulus.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic {
    CNT_FULL  = 1'b0,
    CNT_SPLIT = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/rcs_beat_eval.sv
module rcs_beat_eval #(
  parameter int SYM_W = 8,
  parameter int PC_W  = $clog2(SYM_W + 1)
) (
  input  logic [SYM_W-1:0] sym,
  input  logic [SYM_W-1:0] err,
  output logic             hit,
  output logic [PC_W-1:0]  n_total,
  output logic [PC_W-1:0]  n_fall,
  output logic [PC_W-1:0]  n_rise
);

  logic [SYM_W-1:0] fall_mask;
  logic [SYM_W-1:0] rise_mask;

  for (genvar b = 0; b < SYM_W; b++) begin : g_mask
    assign fall_mask[b] = err[b] & ~sym[b];
    assign rise_mask[b] = err[b] &  sym[b];
  end

  always_comb begin
    n_total = '0;
    n_fall  = '0;
    n_rise  = '0;
    for (int b = 0; b < SYM_W; b++) begin
      n_total = n_total + PC_W'(err[b]);
      n_fall  = n_fall  + PC_W'(fall_mask[b]);
      n_rise  = n_rise  + PC_W'(rise_mask[b]);
    end
    hit = |err;
  end

  always_comb begin
    // R4: the two direction counts partition the corrected bits
    a_r4_split_sum : assert (int'(n_fall) + int'(n_rise) == int'(n_total));
    // R2: a symbol is hit exactly when it carries at least one corrected bit
    a_r2_hit_bits : assert (hit == (n_total != '0));
  end

endmodule

// File: rtl/rcs_accum.sv
module rcs_accum #(
  parameter int                SYM_W  = 8,
  parameter int                PC_W   = $clog2(SYM_W + 1),
  parameter int                SYM_CW = 8,
  parameter int                BIT_CW = 11,
  parameter rcs_pkg::cnt_mode_e MODE  = rcs_pkg::CNT_FULL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              sop,
  input  logic              eop,
  input  logic              fail_in,
  input  logic              hit,
  input  logic [PC_W-1:0]   n_total,
  input  logic [PC_W-1:0]   n_fall,
  input  logic [PC_W-1:0]   n_rise,
  output logic              done_o,
  output logic              pub_go,
  output logic              fail_acc,
  output logic [SYM_CW-1:0] sym_acc,
  output logic [BIT_CW-1:0] a_acc,
  output logic [BIT_CW-1:0] b_acc
);

  logic              open_q, open_d;
  logic              done_q, done_d;
  logic              fail_q, fail_d;
  logic [SYM_CW-1:0] sym_q, sym_d;
  logic [BIT_CW-1:0] a_q, a_d;
  logic [BIT_CW-1:0] b_q, b_d;
  logic [PC_W-1:0]   add_a, add_b;
  logic              sop_go, take;

  if (MODE == rcs_pkg::CNT_SPLIT) begin : g_split
    assign add_a = n_fall;
    assign add_b = n_rise;
  end else begin : g_full
    assign add_a = n_total;
    assign add_b = '0;
  end

  assign sop_go = valid & sop;
  assign take   = valid & (sop | open_q);
  assign pub_go = sop_go & done_q;

  always_comb begin
    open_d = open_q;
    done_d = done_q;
    fail_d = fail_q;
    sym_d  = sym_q;
    a_d    = a_q;
    b_d    = b_q;
    if (sop_go) begin
      open_d = ~eop;
      done_d = eop;
      fail_d = fail_in;
      sym_d  = SYM_CW'(hit);
      a_d    = BIT_CW'(add_a);
      b_d    = BIT_CW'(add_b);
    end else if (take) begin
      fail_d = fail_q | fail_in;
      sym_d  = sym_q + SYM_CW'(hit);
      a_d    = a_q + BIT_CW'(add_a);
      b_d    = b_q + BIT_CW'(add_b);
      if (eop) begin
        open_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      sym_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
    end else if (take) begin
      open_q <= open_d;
      done_q <= done_d;
      fail_q <= fail_d;
      sym_q  <= sym_d;
      a_q    <= a_d;
      b_q    <= b_d;
    end
  end

  assign done_o   = done_q;
  assign fail_acc = fail_q;
  assign sym_acc  = sym_q;
  assign a_acc    = a_q;
  assign b_acc    = b_q;

  // R2: every corrected symbol contributes at least one corrected bit
  a_r2_sym_le_bits : assert property (@(posedge clk) disable iff (!rst_n)
    int'(sym_q) <= int'(a_q) + int'(b_q));

  // R11: a codeword is never both open and closed
  a_r11_open_excl : assert property (@(posedge clk) disable iff (!rst_n)
    !(open_q && done_q));

  // R7: idle beats leave the accumulators untouched
  a_r7_idle_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> ($stable(sym_q) && $stable(a_q) && $stable(b_q)));

endmodule

// File: rtl/rcs_publish.sv
module rcs_publish #(
  parameter int SYM_CW = 8,
  parameter int BIT_CW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pub_go,
  input  logic              fail_acc,
  input  logic [SYM_CW-1:0] sym_acc,
  input  logic [BIT_CW-1:0] a_acc,
  input  logic [BIT_CW-1:0] b_acc,
  output logic              pub_valid,
  output logic              pub_fail,
  output logic [SYM_CW-1:0] pub_sym,
  output logic [BIT_CW-1:0] pub_a,
  output logic [BIT_CW-1:0] pub_b
);

  logic              fail_d;
  logic [SYM_CW-1:0] sym_d;
  logic [BIT_CW-1:0] a_d, b_d;

  always_comb begin
    fail_d = fail_acc;
    sym_d  = fail_acc ? '0 : sym_acc;
    a_d    = fail_acc ? '0 : a_acc;
    b_d    = fail_acc ? '0 : b_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pub_valid <= 1'b0;
    end else begin
      pub_valid <= pub_go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pub_fail <= 1'b0;
      pub_sym  <= '0;
      pub_a    <= '0;
      pub_b    <= '0;
    end else if (pub_go) begin
      pub_fail <= fail_d;
      pub_sym  <= sym_d;
      pub_a    <= a_d;
      pub_b    <= b_d;
    end
  end

  // R5: published values move only on a publication edge
  a_r5_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !pub_go |=> ($stable(pub_sym) && $stable(pub_a) && $stable(pub_b) && $stable(pub_fail)));

  // R8: a failed codeword reports no counts
  a_r8_fail_zero : assert property (@(posedge clk) disable iff (!rst_n)
    (pub_valid && pub_fail) |-> (pub_sym == '0 && pub_a == '0 && pub_b == '0));

endmodule

// File: rtl/rs_corr_stats.sv
module rs_corr_stats #(
  parameter int                 SYM_W  = 8,
  parameter int                 N_MAX  = 255,
  parameter rcs_pkg::cnt_mode_e MODE   = rcs_pkg::CNT_FULL,
  localparam int                SYM_CW = $clog2(N_MAX + 1),
  localparam int                BIT_CW = $clog2(N_MAX * SYM_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [SYM_W-1:0]  in_sym,
  input  logic [SYM_W-1:0]  in_err,
  input  logic              in_fail,
  output logic              stat_valid,
  output logic              stat_fail,
  output logic [SYM_CW-1:0] stat_sym,
  output logic [BIT_CW-1:0] stat_total,
  output logic [BIT_CW-1:0] stat_fall,
  output logic [BIT_CW-1:0] stat_rise
);

  localparam int PC_W = $clog2(SYM_W + 1);

  logic              hit;
  logic [PC_W-1:0]   n_total, n_fall, n_rise;
  logic              done_w, pub_go, fail_acc;
  logic [SYM_CW-1:0] sym_acc;
  logic [BIT_CW-1:0] a_acc, b_acc;
  logic [BIT_CW-1:0] pub_a, pub_b;

  rcs_beat_eval #(.SYM_W(SYM_W), .PC_W(PC_W)) u_eval (
    .sym     (in_sym),
    .err     (in_err),
    .hit     (hit),
    .n_total (n_total),
    .n_fall  (n_fall),
    .n_rise  (n_rise)
  );

  rcs_accum #(
    .SYM_W(SYM_W), .PC_W(PC_W), .SYM_CW(SYM_CW), .BIT_CW(BIT_CW), .MODE(MODE)
  ) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (in_valid),
    .sop      (in_sop),
    .eop      (in_eop),
    .fail_in  (in_fail),
    .hit      (hit),
    .n_total  (n_total),
    .n_fall   (n_fall),
    .n_rise   (n_rise),
    .done_o   (done_w),
    .pub_go   (pub_go),
    .fail_acc (fail_acc),
    .sym_acc  (sym_acc),
    .a_acc    (a_acc),
    .b_acc    (b_acc)
  );

  rcs_publish #(.SYM_CW(SYM_CW), .BIT_CW(BIT_CW)) u_pub (
    .clk       (clk),
    .rst_n     (rst_n),
    .pub_go    (pub_go),
    .fail_acc  (fail_acc),
    .sym_acc   (sym_acc),
    .a_acc     (a_acc),
    .b_acc     (b_acc),
    .pub_valid (stat_valid),
    .pub_fail  (stat_fail),
    .pub_sym   (stat_sym),
    .pub_a     (pub_a),
    .pub_b     (pub_b)
  );

  if (MODE == rcs_pkg::CNT_SPLIT) begin : g_out_split
    assign stat_total = '0;
    assign stat_fall  = pub_a;
    assign stat_rise  = pub_b;
  end else begin : g_out_full
    assign stat_total = pub_a;
    assign stat_fall  = '0;
    assign stat_rise  = '0;
  end

  // R6: a start beat with nothing closed behind it publishes nothing
  a_r6_no_orphan : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop && !done_w) |=> !stat_valid);

  // R5: a publication pulse follows only an accepted start beat
  a_r5_pulse_src : assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_sop) |=> !stat_valid);

endmodule

// File: tb/rs_corr_stats_tb_top.sv
module rs_corr_stats_tb_top;

  localparam int CLK_P  = 10;
  localparam int SW     = 4;
  localparam int NM     = 16;
  localparam int SCW    = $clog2(NM + 1);
  localparam int BCW    = $clog2(NM * SW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_fail = 1'b0;
  logic [SW-1:0] in_sym = '0, in_err = '0;

  logic           f_valid, f_fail, s_valid, s_fail;
  logic [SCW-1:0] f_sym, s_sym;
  logic [BCW-1:0] f_tot, f_fall, f_rise, s_tot, s_fall, s_rise;

  int errors = 0;
  int checks = 0;

  logic [SW-1:0] b_out [0:31];
  logic [SW-1:0] b_err [0:31];
  logic          b_fail [0:31];

  int  sn_fv, sn_ff, sn_fs, sn_ft, sn_ffa, sn_fr;
  int  sn_sv, sn_sf, sn_ss, sn_st, sn_sfa, sn_sr;
  int  p_valid = 0, p_fail, p_sym, p_tot, p_fall, p_rise;

  always #(CLK_P/2) clk = ~clk;

  rs_corr_stats #(.SYM_W(SW), .N_MAX(NM), .MODE(rcs_pkg::CNT_FULL)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_sym(in_sym), .in_err(in_err), .in_fail(in_fail),
    .stat_valid(f_valid), .stat_fail(f_fail), .stat_sym(f_sym),
    .stat_total(f_tot), .stat_fall(f_fall), .stat_rise(f_rise));

  rs_corr_stats #(.SYM_W(SW), .N_MAX(NM), .MODE(rcs_pkg::CNT_SPLIT)) dut_s_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_sym(in_sym), .in_err(in_err), .in_fail(in_fail),
    .stat_valid(s_valid), .stat_fail(s_fail), .stat_sym(s_sym),
    .stat_total(s_tot), .stat_fall(s_fall), .stat_rise(s_rise));

  task automatic chk(string tag, string fld, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, fld, act, exp);
    end
  endtask

  task automatic idle();
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_fail = 1'b0;
    in_sym = '0; in_err = '0;
  endtask

  task automatic take_snap();
    sn_fv = int'(f_valid); sn_ff = int'(f_fail); sn_fs = int'(f_sym);
    sn_ft = int'(f_tot); sn_ffa = int'(f_fall); sn_fr = int'(f_rise);
    sn_sv = int'(s_valid); sn_sf = int'(s_fail); sn_ss = int'(s_sym);
    sn_st = int'(s_tot); sn_sfa = int'(s_fall); sn_sr = int'(s_rise);
  endtask

  task automatic drive_cw(int n, bit closed, bit gaps);
    int ne = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ne++; if (ne == 2) take_snap();
      in_valid = 1'b1; in_sop = (i == 0); in_eop = closed && (i == n-1);
      in_sym = b_out[i]; in_err = b_err[i]; in_fail = b_fail[i];
      if (gaps && i < n-1) begin
        @(negedge clk); ne++; if (ne == 2) take_snap();
        in_valid = 1'b0; in_sop = 1'b1; in_eop = 1'b1;
        in_sym = '1; in_err = '1; in_fail = 1'b1;
      end
    end
    @(negedge clk); ne++; if (ne == 2) take_snap();
    idle();
  endtask

  task automatic drive_stray(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b0;
      in_sym = 4'h3; in_err = '1; in_fail = 1'b1;
    end
    @(negedge clk);
    idle();
  endtask

  task automatic fill(int n, int kind);
    for (int i = 0; i < 32; i++) begin
      b_out[i] = '0; b_err[i] = '0; b_fail[i] = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      b_out[i] = SW'(i * 3 + 1);
      case (kind)
        0: b_err[i] = (i % 2 == 1) ? SW'(i + 1) : '0;
        1: b_err[i] = SW'(i * 5);
        2: b_err[i] = SW'(1 << (i % 4));
        3: b_err[i] = SW'(i + 2);
        default: begin b_err[i] = '1; b_out[i] = (i % 2 == 1) ? 4'hA : 4'h5; end
      endcase
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "R5 valid(full)", sn_fv, p_valid);
    chk(tag, "R5 valid(split)", sn_sv, p_valid);
    if (p_valid != 0) begin
      chk(tag, "R8 fail(full)", sn_ff, p_fail);
      chk(tag, "R8 fail(split)", sn_sf, p_fail);
      chk(tag, "R2 sym(full)", sn_fs, p_sym);
      chk(tag, "R2 sym(split)", sn_ss, p_sym);
      chk(tag, "R3 total", sn_ft, p_tot);
      chk(tag, "R3 fall zero in full", sn_ffa, 0);
      chk(tag, "R3 rise zero in full", sn_fr, 0);
      chk(tag, "R4 total zero in split", sn_st, 0);
      chk(tag, "R4 fall", sn_sfa, p_fall);
      chk(tag, "R4 rise", sn_sr, p_rise);
    end
  endtask

  task automatic run_cw(string tag, int n, bit closed, bit gaps);
    int fl = 0, sy = 0, to = 0, fa = 0, ri = 0;
    drive_cw(n, closed, gaps);
    compare(tag);
    for (int i = 0; i < n; i++) begin
      if (b_fail[i]) fl = 1;
      if (b_err[i] != '0) sy++;
      for (int b = 0; b < SW; b++) begin
        if (b_err[i][b]) begin
          to++;
          if (b_out[i][b]) ri++; else fa++;
        end
      end
    end
    p_valid = closed ? 1 : 0;
    p_fail  = fl;
    p_sym   = fl ? 0 : sy;
    p_tot   = fl ? 0 : to;
    p_fall  = fl ? 0 : fa;
    p_rise  = fl ? 0 : ri;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "valid during reset", int'(f_valid) + int'(s_valid), 0);
    chk("R1", "counts during reset",
        int'(f_sym) + int'(f_tot) + int'(s_fall) + int'(s_rise) + int'(f_fail), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "counts after release",
        int'(f_valid) + int'(s_sym) + int'(s_fail) + int'(f_tot), 0);
  endtask

  task automatic t_hold();
    int h_sym = int'(f_sym);
    int h_fall = int'(s_fall);
    repeat (3) @(negedge clk);
    chk("R5 hold", "valid low when idle", int'(f_valid) + int'(s_valid), 0);
    chk("R5 hold", "sym held", int'(f_sym), h_sym);
    chk("R5 hold", "fall held", int'(s_fall), h_fall);
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    idle();
    t_reset();
    fill(5, 0);  run_cw("R6 first start beat", 5, 1'b1, 1'b0);
    fill(6, 1);  run_cw("R2 R3 R4 basic", 6, 1'b1, 1'b0);
    t_hold();
    fill(4, 2);  run_cw("R2 R3 R4 second pattern", 4, 1'b1, 1'b1);
    drive_stray(2);
    fill(5, 3);  b_fail[2] = 1'b1;
    run_cw("R7 gaps and strays ignored", 5, 1'b1, 1'b0);
    fill(1, 4);  run_cw("R8 failed codeword", 1, 1'b1, 1'b0);
    fill(NM, 4); run_cw("R9 single beat", NM, 1'b1, 1'b0);
    fill(3, 1);  run_cw("R10 full-length all bits", 3, 1'b0, 1'b0);
    fill(4, 3);  run_cw("R11 abort publishes nothing", 4, 1'b1, 1'b0);
    fill(2, 0);  run_cw("R11 restart counted", 2, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule